// File: doc/BRIEF.md
# Memory Card SPI Start-up Sequencer

This block is the controller that takes a freshly powered memory card from its native bus mode into SPI mode. It does not move bits itself. It asks an external byte engine for idle clock bytes sent with chip select high, and it hands that engine one command at a time as an index, a 32-bit argument and a CRC byte. The engine returns the card's one-byte status reply, or reports a timeout.

From the reply to the interface-condition command, the sequencer picks one of two initialise loops. The older-card loop uses byte addressing. The newer-card loop advertises high-capacity support and uses block addressing. Each loop is retried up to a parameterised limit. The sequence ends by setting the block length. The block then reports done or fail, a card-type code and an addressing flag for the transfer logic. It also drives a slow/fast bit-clock select.

A one-cycle `start` pulse begins the sequence, or restarts it from any state.

Top module: `sdspi_init_seq`

## Requirements
- R1: After reset, and in the cycle after any `start` pulse, `done`, `fail` and `clk_fast` are 0. A `start` pulse in any state restarts the sequence from the idle-fill phase.
- R2: Before the first command, the block requests exactly FILL_BYTES (default 16) idle bytes by holding `fill_req` and counting `fill_ack` pulses. `fill_req` and `req_valid` are never high together, and `clk_fast` stays 0 throughout.
- R3: The first command has index 0, argument 0 and CRC byte 0x95, and 0x95 is also the CRC byte of every other command except index 8. A reply other than exactly 0x01, or a timeout, ends in `fail`. Command fields hold steady while `req_valid` waits for `rsp_valid`.
- R4: The second command has index 8, argument 0x000001AA and CRC 0x87. A reply of 0x01 selects the new-card loop and 0x05 selects the old-card loop. Any other reply, or a timeout, ends in `fail`.
- R5: The old-card loop repeats index 55 followed by index 41 with argument 0 until index 41 replies 0x00.
- R6: Each iteration of the new-card loop issues index 58, then 55, then 41 with argument 0x40000000. A 0x00 reply to index 41 is followed by a single extra index 58.
- R7: Every new-card iteration is preceded by exactly GAP_CYCLES cycles with neither `req_valid` nor `fill_req` high.
- R8: After MAX_ITER index-41 replies that are non-zero or timeouts, the block ends in `fail` without issuing a further command.
- R9: After a successful loop, the block sends index 16 with argument 512. A 0x00 reply raises `done` and `clk_fast`, and any other reply or a timeout ends in `fail`.
- R10: `card_type` is 1 for the old-card path and 2 for the new-card path while `done` is high, and 0 otherwise. `byte_addr` is 1 (address scale 512) only while `done` is high on the old-card path.
- R11: Replies and timeouts for index 55 and 58 do not change the course of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts the sequence |
| fill_req | output | 1 | Request for one idle byte sent with chip select high |
| fill_ack | input | 1 | Pulse: one idle byte was sent |
| req_valid | output | 1 | Command request pending, held until `rsp_valid` |
| req_idx | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_crc | output | 8 | Command CRC byte |
| rsp_valid | input | 1 | Pulse: reply or timeout for the pending command |
| rsp_timeout | input | 1 | With `rsp_valid`: the card did not reply |
| rsp_r1 | input | 8 | With `rsp_valid`: the status byte |
| clk_fast | output | 1 | 0 selects the slow bit clock, 1 the fast one |
| done | output | 1 | Sequence finished successfully |
| fail | output | 1 | Sequence aborted |
| card_type | output | 2 | 0 none/failed, 1 old card, 2 new card |
| byte_addr | output | 1 | Transfers use byte addresses (scale 512) |

## Verification
The hardest case to reach from the ports is exhausting the retry limit. It takes exactly MAX_ITER failed index-41 replies, some of them timeouts, mixed in with arbitrary replies to indexes 55 and 58. The bench overrides the limit to a small value and uses a reactive card model that returns a chosen number of busy replies. Busy counts land below, at and above the limit on both loop paths, so the limit-minus-one success and the exact-limit failure are both hit.

A restart in the middle of the new-card loop is also hard to reach. The bench waits until the model has answered several iterations and the sequencer is sitting in its inter-iteration gap, then pulses `start` and expects a complete fresh sequence.

// File: rtl/sdspi_init_pkg.sv
package sdspi_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_RST,
        ST_IFC,
        ST_V1_APP,
        ST_V1_INIT,
        ST_V2_GAP,
        ST_V2_OCR,
        ST_V2_APP,
        ST_V2_INIT,
        ST_V2_OCR_FIN,
        ST_BLKLEN,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_OLD  = 2'd1,
        CARD_NEW  = 2'd2
    } card_kind_t;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  crc;
    } cmd_frame_t;

    localparam logic [7:0]  R1_IDLE_ONLY    = 8'h01;
    localparam logic [7:0]  R1_IDLE_ILLEGAL = 8'h05;
    localparam logic [7:0]  CRC_DEFAULT     = 8'h95;
    localparam logic [7:0]  CRC_IFCOND      = 8'h87;
    localparam logic [31:0] ARG_IFCOND      = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS         = 32'h4000_0000;
    localparam logic [31:0] ARG_BLOCK_LEN   = 32'd512;

    localparam logic [5:0] IDX_RESET   = 6'd0;
    localparam logic [5:0] IDX_IFCOND  = 6'd8;
    localparam logic [5:0] IDX_BLKLEN  = 6'd16;
    localparam logic [5:0] IDX_INIT    = 6'd41;
    localparam logic [5:0] IDX_APP     = 6'd55;
    localparam logic [5:0] IDX_OCR     = 6'd58;

    function automatic cmd_frame_t frame_for(seq_state_t s);
        cmd_frame_t f;
        f = '{idx: IDX_RESET, arg: 32'd0, crc: CRC_DEFAULT};
        case (s)
            ST_IFC:        f = '{idx: IDX_IFCOND, arg: ARG_IFCOND, crc: CRC_IFCOND};
            ST_V1_APP,
            ST_V2_APP:     f.idx = IDX_APP;
            ST_V1_INIT:    f.idx = IDX_INIT;
            ST_V2_INIT:    f = '{idx: IDX_INIT, arg: ARG_HCS, crc: CRC_DEFAULT};
            ST_V2_OCR,
            ST_V2_OCR_FIN: f.idx = IDX_OCR;
            ST_BLKLEN:     f = '{idx: IDX_BLKLEN, arg: ARG_BLOCK_LEN, crc: CRC_DEFAULT};
            default:       f = '{idx: IDX_RESET, arg: 32'd0, crc: CRC_DEFAULT};
        endcase
        return f;
    endfunction

    function automatic logic issues_cmd(seq_state_t s);
        return (s == ST_RST) || (s == ST_IFC) || (s == ST_V1_APP) ||
               (s == ST_V1_INIT) || (s == ST_V2_OCR) || (s == ST_V2_APP) ||
               (s == ST_V2_INIT) || (s == ST_V2_OCR_FIN) || (s == ST_BLKLEN);
    endfunction

endpackage

// File: rtl/sdspi_iter_ctr.sv
module sdspi_iter_ctr #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign last = (cnt == LAST_VAL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_VAL);

endmodule

// File: rtl/sdspi_gap_timer.sv
module sdspi_gap_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] END_VAL = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    assign expired = run && (cnt == END_VAL);

    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= END_VAL);

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
    import sdspi_init_pkg::*;
#(
    parameter int FILL_BYTES = 16,
    parameter int MAX_ITER   = 5000,
    parameter int GAP_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        fill_req,
    input  logic        fill_ack,
    output logic        req_valid,
    output logic [5:0]  req_idx,
    output logic [31:0] req_arg,
    output logic [7:0]  req_crc,
    input  logic        rsp_valid,
    input  logic        rsp_timeout,
    input  logic [7:0]  rsp_r1,
    output logic        clk_fast,
    output logic        done,
    output logic        fail,
    output logic [1:0]  card_type,
    output logic        byte_addr
);
    localparam int FW = (FILL_BYTES > 1) ? $clog2(FILL_BYTES) : 1;
    localparam logic [FW-1:0] FILL_LAST = FW'(FILL_BYTES - 1);

    seq_state_t state, state_nx;
    cmd_frame_t frame;
    logic [FW-1:0] fill_cnt;
    logic path_new;
    logic accept, reply_zero, reply_idle;
    logic init_miss, iter_last, gap_done;

    assign frame      = frame_for(state);
    assign req_valid  = issues_cmd(state);
    assign req_idx    = frame.idx;
    assign req_arg    = frame.arg;
    assign req_crc    = frame.crc;
    assign fill_req   = (state == ST_FILL);

    assign accept     = req_valid && rsp_valid;
    assign reply_zero = !rsp_timeout && (rsp_r1 == 8'h00);
    assign reply_idle = !rsp_timeout && (rsp_r1 == R1_IDLE_ONLY);
    assign init_miss  = accept && !reply_zero &&
                        ((state == ST_V1_INIT) || (state == ST_V2_INIT));

    sdspi_iter_ctr #(.LIMIT(MAX_ITER)) u_iter (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .inc  (init_miss),
        .last (iter_last)
    );

    sdspi_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_V2_GAP),
        .expired (gap_done)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_FILL:
                if (fill_ack && fill_cnt == FILL_LAST) state_nx = ST_RST;
            ST_RST:
                if (accept) state_nx = reply_idle ? ST_IFC : ST_FAIL;
            ST_IFC:
                if (accept) begin
                    if (reply_idle)
                        state_nx = ST_V2_GAP;
                    else if (!rsp_timeout && rsp_r1 == R1_IDLE_ILLEGAL)
                        state_nx = ST_V1_APP;
                    else
                        state_nx = ST_FAIL;
                end
            ST_V1_APP:
                if (accept) state_nx = ST_V1_INIT;
            ST_V1_INIT:
                if (accept) begin
                    if (reply_zero)     state_nx = ST_BLKLEN;
                    else if (iter_last) state_nx = ST_FAIL;
                    else                state_nx = ST_V1_APP;
                end
            ST_V2_GAP:
                if (gap_done) state_nx = ST_V2_OCR;
            ST_V2_OCR:
                if (accept) state_nx = ST_V2_APP;
            ST_V2_APP:
                if (accept) state_nx = ST_V2_INIT;
            ST_V2_INIT:
                if (accept) begin
                    if (reply_zero)     state_nx = ST_V2_OCR_FIN;
                    else if (iter_last) state_nx = ST_FAIL;
                    else                state_nx = ST_V2_GAP;
                end
            ST_V2_OCR_FIN:
                if (accept) state_nx = ST_BLKLEN;
            ST_BLKLEN:
                if (accept) state_nx = reply_zero ? ST_DONE : ST_FAIL;
            default: state_nx = state;
        endcase
        if (start) state_nx = ST_FILL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fill_cnt <= '0;
            path_new <= 1'b0;
            clk_fast <= 1'b0;
        end else begin
            state <= state_nx;
            if (start) begin
                fill_cnt <= '0;
                path_new <= 1'b0;
                clk_fast <= 1'b0;
            end else begin
                if (state == ST_FILL && fill_ack) fill_cnt <= fill_cnt + 1'b1;
                if (state == ST_IFC && accept) path_new <= reply_idle;
                if (state == ST_BLKLEN && accept && reply_zero) clk_fast <= 1'b1;
            end
        end
    end

    assign done      = (state == ST_DONE);
    assign fail      = (state == ST_FAIL);
    assign card_type = done ? (path_new ? CARD_NEW : CARD_OLD) : CARD_NONE;
    assign byte_addr = done && !path_new;

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !fail && !clk_fast));

    // R2
    fill_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_req && req_valid));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid && !start) |=>
            (req_valid && $stable(req_idx) && $stable(req_arg) && $stable(req_crc)));

    // R9
    done_fast_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> clk_fast);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(req_valid && rsp_valid && !rsp_timeout &&
                              req_idx == IDX_BLKLEN && rsp_r1 == 8'h00));

    // R10
    done_type_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (card_type == CARD_OLD || card_type == CARD_NEW));

    // R1
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

endmodule

// File: tb/sdspi_init_seq_test.sv
`timescale 1ns/1ps
module sdspi_init_seq_test;
    localparam int FILL = 16;
    localparam int ITER = 6;
    localparam int GAP  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic fill_req, req_valid, clk_fast, done, fail, byte_addr;
    logic fill_ack = 1'b0;
    logic rsp_valid = 1'b0;
    logic rsp_timeout = 1'b0;
    logic [7:0] rsp_r1 = 8'h00;
    logic [5:0] req_idx;
    logic [31:0] req_arg;
    logic [7:0] req_crc;
    logic [1:0] card_type;

    always #2 clk = ~clk;

    sdspi_init_seq #(.FILL_BYTES(FILL), .MAX_ITER(ITER), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .start(start),
        .fill_req(fill_req), .fill_ack(fill_ack),
        .req_valid(req_valid), .req_idx(req_idx), .req_arg(req_arg), .req_crc(req_crc),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_r1(rsp_r1),
        .clk_fast(clk_fast), .done(done), .fail(fail),
        .card_type(card_type), .byte_addr(byte_addr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scenario for the card model
    logic [7:0] r0, r8, r16;
    bit to0, to8, to16;
    int n_busy;

    // logs
    int n_fill, n0, n8, n41, n55, n58, n16;
    logic [31:0] a0, a8, a41, a16;
    logic [7:0] c0, c8, c41, c16;
    int early_cmd, fast_fill;
    int low_cnt, prev_idx, wait_cnt;
    bit prev_bad, seen_req;

    task automatic clear_log();
        n_fill = 0; n0 = 0; n8 = 0; n41 = 0; n55 = 0; n58 = 0; n16 = 0;
        a0 = 0; a8 = 0; a41 = 0; a16 = 0; c0 = 0; c8 = 0; c41 = 0; c16 = 0;
        early_cmd = 0; fast_fill = 0; low_cnt = 0; prev_idx = 99; prev_bad = 0;
    endtask

    function automatic logic [7:0] nz7();
        logic [7:0] v;
        v = 8'($urandom_range(1, 127));
        return v;
    endfunction

    // reactive card model, acting at falling edges
    always @(negedge clk) begin
        bit to;
        logic [7:0] r;
        int gexp;
        if (rst) begin
            rsp_valid = 0; rsp_timeout = 0; fill_ack = 0;
            seen_req = 0; wait_cnt = 0;
        end else begin
            rsp_valid = 0; rsp_timeout = 0; fill_ack = 0;
            if (req_valid) begin
                if (!seen_req) begin
                    seen_req = 1;
                    if (n_fill < FILL) early_cmd++;
                    if (prev_idx != 99) begin
                        gexp = (req_idx == 6'd58 &&
                                (prev_idx == 8 || (prev_idx == 41 && prev_bad))) ? GAP : 0;
                        chk("R7", "idle cycles before command", low_cnt, gexp);
                    end
                    low_cnt = 0;
                    case (req_idx)
                        6'd0:  begin n0++;  a0 = req_arg;  c0 = req_crc;  end
                        6'd8:  begin n8++;  a8 = req_arg;  c8 = req_crc;  end
                        6'd16: begin n16++; a16 = req_arg; c16 = req_crc; end
                        6'd41: begin n41++; a41 = req_arg; c41 = req_crc; end
                        6'd55: n55++;
                        6'd58: n58++;
                        default: early_cmd++;
                    endcase
                    wait_cnt = $urandom_range(0, 2);
                end
                if (wait_cnt == 0) begin
                    to = 0; r = 8'h00;
                    case (req_idx)
                        6'd0:  begin to = to0;  r = r0;  end
                        6'd8:  begin to = to8;  r = r8;  end
                        6'd16: begin to = to16; r = r16; end
                        6'd41: begin
                            if (n41 <= n_busy) begin
                                to = ($urandom_range(0, 3) == 0);
                                r = nz7();
                            end
                        end
                        default: begin
                            to = ($urandom_range(0, 7) == 0);
                            r = 8'($urandom_range(0, 127));
                        end
                    endcase
                    rsp_valid = 1; rsp_timeout = to; rsp_r1 = r;
                    prev_idx = int'(req_idx);
                    prev_bad = to || (r != 8'h00);
                    seen_req = 0;
                end else begin
                    wait_cnt--;
                end
            end else if (fill_req) begin
                if (clk_fast) fast_fill++;
                if ($urandom_range(0, 2) == 0) begin
                    fill_ack = 1;
                    n_fill++;
                end
            end else begin
                low_cnt++;
            end
        end
    end

    task automatic run_case(string tag);
        int t;
        int stage;
        bit ok, nw;
        int e41;
        @(negedge clk); #1;
        clear_log();
        start = 1;
        @(negedge clk); #1;
        start = 0;
        chk("R1", {tag, " done cleared by start"}, done, 0);
        chk("R1", {tag, " fail cleared by start"}, fail, 0);
        chk("R1", {tag, " slow clock after start"}, clk_fast, 0);
        t = 0;
        while (!(done || fail) && t < 3000) begin
            @(negedge clk); #1;
            t++;
        end
        // expected outcome
        nw = (r8 == 8'h01);
        if (to0 || r0 != 8'h01) stage = 0;
        else if (to8 || (r8 != 8'h01 && r8 != 8'h05)) stage = 1;
        else if (n_busy >= ITER) stage = 2;
        else if (to16 || r16 != 8'h00) stage = 3;
        else stage = 4;
        ok = (stage == 4);
        chk("R9", {tag, " done"}, done, ok);
        chk("R3", {tag, " fail"}, fail, !ok);
        chk("R10", {tag, " card_type"}, card_type, ok ? (nw ? 2 : 1) : 0);
        chk("R10", {tag, " byte_addr"}, byte_addr, ok && !nw);
        chk("R9", {tag, " clk_fast"}, clk_fast, ok);
        chk("R2", {tag, " idle fill bytes"}, n_fill, FILL);
        chk("R2", {tag, " commands during fill or unknown"}, early_cmd, 0);
        chk("R2", {tag, " fast clock during fill"}, fast_fill, 0);
        chk("R3", {tag, " reset cmd count"}, n0, 1);
        chk("R3", {tag, " reset cmd arg/crc"}, {a0, c0}, {32'd0, 8'h95});
        chk("R4", {tag, " ifcond count"}, n8, stage >= 1 ? 1 : 0);
        if (stage >= 1)
            chk("R4", {tag, " ifcond arg/crc"}, {a8, c8}, {32'h1AA, 8'h87});
        e41 = (stage >= 2) ? ((n_busy + 1 < ITER) ? n_busy + 1 : ITER) : 0;
        chk("R8", {tag, " init cmd count"}, n41, e41);
        chk("R11", {tag, " app cmd count"}, n55, e41);
        if (stage >= 2) begin
            if (nw) begin
                chk("R6", {tag, " init arg/crc"}, {a41, c41}, {32'h4000_0000, 8'h95});
                chk("R6", {tag, " ocr count"}, n58, e41 + (n_busy < ITER ? 1 : 0));
            end else begin
                chk("R5", {tag, " init arg/crc"}, {a41, c41}, {32'd0, 8'h95});
                chk("R5", {tag, " no ocr"}, n58, 0);
            end
        end
        chk("R9", {tag, " blklen count"}, n16, stage >= 3 ? 1 : 0);
        if (stage >= 3)
            chk("R9", {tag, " blklen arg/crc"}, {a16, c16}, {32'd512, 8'h95});
    endtask

    task automatic set_case(logic [7:0] a, logic [7:0] b, int busy, logic [7:0] c);
        r0 = a; r8 = b; n_busy = busy; r16 = c;
        to0 = 0; to8 = 0; to16 = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int u;
        void'($urandom(32'd1234));
        clear_log();
        set_case(8'h01, 8'h01, 0, 8'h00);
        repeat (4) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        chk("R1", "reset done", done, 0);
        chk("R1", "reset fail", fail, 0);
        chk("R1", "reset clk_fast", clk_fast, 0);
        chk("R2", "reset fill_req", fill_req, 0);
        chk("R3", "reset req_valid", req_valid, 0);
        chk("R10", "reset card_type", card_type, 0);

        // directed corners
        set_case(8'h01, 8'h05, 0, 8'h00);        run_case("old card first try");
        set_case(8'h01, 8'h01, 0, 8'h00);        run_case("new card first try");
        set_case(8'h01, 8'h05, ITER - 1, 8'h00); run_case("old card last iteration");
        set_case(8'h01, 8'h01, ITER - 1, 8'h00); run_case("new card last iteration");
        set_case(8'h01, 8'h05, ITER, 8'h00);     run_case("old card limit");
        set_case(8'h01, 8'h01, ITER, 8'h00);     run_case("new card limit");
        set_case(8'h00, 8'h01, 0, 8'h00);        run_case("reset reply zero");
        set_case(8'h01, 8'h03, 0, 8'h00);        run_case("ifcond bad reply");
        set_case(8'h01, 8'h01, 1, 8'h04);        run_case("blklen rejected");
        set_case(8'h01, 8'h01, 0, 8'h00); to8 = 1; run_case("ifcond timeout");

        // restart in the middle of the new-card loop
        set_case(8'h01, 8'h01, 100, 8'h00);
        @(negedge clk); #1;
        clear_log();
        start = 1;
        @(negedge clk); #1;
        start = 0;
        while (!(n41 >= 2 && !req_valid && !fill_req && !rsp_valid) && !fail) begin
            @(negedge clk); #1;
        end
        chk("R1", "restart reached loop", fail, 0);
        n_busy = 1;
        run_case("restart mid loop");

        // random scenarios
        for (int k = 0; k < 40; k++) begin
            u = $urandom_range(0, 99);
            r0 = (u < 15) ? 8'($urandom_range(0, 127)) : 8'h01;
            to0 = (u >= 95);
            u = $urandom_range(0, 9);
            r8 = (u < 4) ? 8'h01 : (u < 8) ? 8'h05 : 8'($urandom_range(0, 127));
            to8 = ($urandom_range(0, 19) == 0);
            n_busy = $urandom_range(0, ITER + 1);
            u = $urandom_range(0, 9);
            r16 = (u < 8) ? 8'h00 : 8'($urandom_range(0, 127));
            to16 = ($urandom_range(0, 19) == 0);
            run_case("random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule